// File: doc/BRIEF.md
# Interrupt Vector Priority Resolver

This block keeps the interrupt state of one processing core across a parameterized vector space (256 vectors by default). For every vector it holds three bits: pending (a request has been accepted but not yet taken by the core), in service (the core has taken it and has not yet signalled completion) and level (the last accepted request for that vector was level-triggered). A task-priority register set by software completes the state.

From that state the block derives a processor priority and presents at most one vector to the core. That vector is the highest pending one, and it is shown only when its priority class (upper four bits) lies strictly above the processor priority. The core takes the offered vector with an acknowledge strobe. When the core finishes servicing, it raises an end-of-interrupt strobe. The block then retires the highest vector in service and reports that vector and its trigger kind on a one-cycle notification, so that a level-triggered source can be re-armed upstream.

Routing, the register bus and the timer sit outside. Requests arrive already addressed to this core, on a single accept port.

Top module: `vec_prio_resolver`

## Requirements
- R1: After reset no vector is pending, in service or marked level, the task priority is 0x00, `ppr` reads 0x00, and `dlv_valid`, `eoi_done` and `acc_ok` are low.
- R2: While both enables are high, a request on the accept port for a vector that is not pending makes `acc_ok` high in that cycle and marks the vector pending from the next cycle. A request for a vector that is already pending gives `acc_ok` low and changes nothing.
- R3: While `hw_en` or `sw_en` is low, every request is refused (`acc_ok` low) and the pending set is left unchanged.
- R4: The candidate is the highest-numbered pending vector. Vector v lives in word v[7:5], bit v[4:0], and a higher word outranks any bit of a lower word.
- R5: Let I be the highest vector in service, or 0 if none is in service. `ppr` equals the task priority when TPR[7:4] >= I[7:4]. Otherwise it equals I with its low four bits cleared.
- R6: `dlv_valid` is high only when (candidate & 0xF0) > `ppr`, compared as 8-bit numbers. A vector below 0x10 is therefore never delivered, and a candidate whose class equals the task-priority class is held back.
- R7: An acknowledge while `dlv_valid` is high moves the offered vector from pending to in service. An acknowledge while `dlv_valid` is low has no effect.
- R8: An end-of-interrupt retires the highest vector in service. In the next cycle `eoi_done` is high for one cycle with `eoi_vector` set to that vector. With nothing in service the strobe has no effect and produces no notification.
- R9: An accepted request records its trigger kind for its vector: `acc_level`=1 marks it level, 0 marks it edge. On retirement, `eoi_level` reports the recorded kind and the record is cleared.
- R10: An acknowledge that coincides with an accept acts on the state before the accept. An acknowledge that coincides with an end-of-interrupt has both effects: the prior highest in-service vector retires and the offered vector enters service.
- R11: A task-priority write updates the register at the clock edge, and `ppr` together with `dlv_valid` reflect it in the following cycle without further delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| hw_en | input | 1 | Hardware enable for request acceptance |
| sw_en | input | 1 | Software enable for request acceptance |
| acc_valid | input | 1 | Request present on the accept port |
| acc_vector | input | 8 | Vector of the request |
| acc_level | input | 1 | 1 = level-triggered request, 0 = edge |
| acc_ok | output | 1 | Request accepted in this cycle |
| ack | input | 1 | Core takes the offered vector |
| eoi | input | 1 | Core signals end of interrupt |
| tpr_we | input | 1 | Task-priority write strobe |
| tpr_wdata | input | 8 | New task priority |
| dlv_valid | output | 1 | A vector is offered to the core |
| dlv_vector | output | 8 | Offered vector |
| ppr | output | 8 | Current processor priority |
| eoi_done | output | 1 | One-cycle retirement notification |
| eoi_vector | output | 8 | Retired vector |
| eoi_level | output | 1 | Retired vector was level-triggered |

## Verification
Two pairs of strobes can meet in one clock edge, and the bench drives both. In the first, acknowledge and end-of-interrupt coincide: one vector is in service and a higher one is on offer. The bench expects the retirement notification to name the older vector, the newer vector to stay in service, and the processor priority to follow the newer vector. In the second, an accept arrives in the same cycle as an acknowledge. The bench expects the acknowledge to take the vector that was offered before the edge, while the new request is accepted and is offered only after that.

// File: rtl/vpr_pkg.sv
package vpr_pkg;

   // Structure of the highest-set-bit search.
   typedef enum logic [0:0] {
      SCAN_WORD = 1'b0,   // word-nonzero prefilter, then bit within word
      SCAN_FLAT = 1'b1    // single linear search over every bit
   } scan_e;

   localparam int DEF_NUM_VEC   = 256;
   localparam int DEF_WORD_W    = 32;
   localparam int DEF_CLASS_LSB = 4;

endpackage

// File: rtl/vpr_find_highest.sv
module vpr_find_highest
   import vpr_pkg::*;
#(
   parameter int    NUM_BITS = DEF_NUM_VEC,
   parameter int    WORD_W   = DEF_WORD_W,
   parameter scan_e STYLE    = SCAN_WORD,
   localparam int   IDX_W    = $clog2(NUM_BITS)
) (
   input  logic [NUM_BITS-1:0] bits_i,
   output logic                found_o,
   output logic [IDX_W-1:0]    idx_o
);

   if (STYLE == SCAN_WORD) begin : g_word
      localparam int NUM_WORDS = NUM_BITS / WORD_W;

      logic [NUM_WORDS-1:0] word_nz;
      logic [WORD_W-1:0]    sel_word;
      int                   wsel;
      int                   bsel;

      for (genvar w = 0; w < NUM_WORDS; w++) begin : g_nz
         assign word_nz[w] = |bits_i[w*WORD_W +: WORD_W];
      end

      always_comb begin
         wsel = 0;
         for (int w = 0; w < NUM_WORDS; w++) begin
            if (word_nz[w]) wsel = w;
         end
         sel_word = bits_i[wsel*WORD_W +: WORD_W];
         bsel = 0;
         for (int b = 0; b < WORD_W; b++) begin
            if (sel_word[b]) bsel = b;
         end
      end

      assign found_o = |word_nz;
      assign idx_o   = IDX_W'(wsel * WORD_W + bsel);
   end else begin : g_flat
      int fsel;

      always_comb begin
         fsel = 0;
         for (int i = 0; i < NUM_BITS; i++) begin
            if (bits_i[i]) fsel = i;
         end
      end

      assign found_o = |bits_i;
      assign idx_o   = IDX_W'(fsel);
   end

endmodule

// File: rtl/vpr_prio_calc.sv
module vpr_prio_calc #(
   parameter int  VEC_W     = 8,
   parameter int  CLASS_LSB = 4,
   localparam int CLS_W     = VEC_W - CLASS_LSB
) (
   input  logic [VEC_W-1:0] tpr_i,
   input  logic             isr_found_i,
   input  logic [CLS_W-1:0] isr_cls_i,
   output logic [VEC_W-1:0] ppr_o
);

   logic [CLS_W-1:0] tpr_cls;
   logic [CLS_W-1:0] svc_cls;

   assign tpr_cls = tpr_i[VEC_W-1:CLASS_LSB];
   assign svc_cls = isr_found_i ? isr_cls_i : '0;
   assign ppr_o   = (tpr_cls >= svc_cls) ? tpr_i : {svc_cls, {CLASS_LSB{1'b0}}};

endmodule

// File: rtl/vpr_deliver_gate.sv
module vpr_deliver_gate #(
   parameter int VEC_W     = 8,
   parameter int CLASS_LSB = 4
) (
   input  logic             cand_found_i,
   input  logic [VEC_W-1:0] cand_idx_i,
   input  logic [VEC_W-1:0] ppr_i,
   output logic             dlv_valid_o,
   output logic [VEC_W-1:0] dlv_vector_o
);

   logic [VEC_W-1:0] cand_cls;

   assign cand_cls     = {cand_idx_i[VEC_W-1:CLASS_LSB], {CLASS_LSB{1'b0}}};
   assign dlv_valid_o  = cand_found_i && (cand_cls > ppr_i);
   assign dlv_vector_o = cand_idx_i;

endmodule

// File: rtl/vec_prio_resolver.sv
module vec_prio_resolver
   import vpr_pkg::*;
#(
   parameter int    NUM_VEC   = DEF_NUM_VEC,
   parameter int    WORD_W    = DEF_WORD_W,
   parameter int    CLASS_LSB = DEF_CLASS_LSB,
   parameter scan_e STYLE     = SCAN_WORD,
   localparam int   VEC_W     = $clog2(NUM_VEC)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             hw_en,
   input  logic             sw_en,
   input  logic             acc_valid,
   input  logic [VEC_W-1:0] acc_vector,
   input  logic             acc_level,
   output logic             acc_ok,
   input  logic             ack,
   input  logic             eoi,
   input  logic             tpr_we,
   input  logic [VEC_W-1:0] tpr_wdata,
   output logic             dlv_valid,
   output logic [VEC_W-1:0] dlv_vector,
   output logic [VEC_W-1:0] ppr,
   output logic             eoi_done,
   output logic [VEC_W-1:0] eoi_vector,
   output logic             eoi_level
);

   // ---------------------------------------------------------------
   // Elaboration-time parameter checks
   // ---------------------------------------------------------------
   if ((1 << VEC_W) != NUM_VEC) begin : g_chk_pow2
      $error("NUM_VEC must be a power of two");
   end
   if ((WORD_W < 1) || ((NUM_VEC % WORD_W) != 0)) begin : g_chk_word
      $error("NUM_VEC must be a whole number of words");
   end
   if ((CLASS_LSB < 1) || (CLASS_LSB >= VEC_W)) begin : g_chk_class
      $error("CLASS_LSB must lie inside the vector width");
   end

   localparam int CLS_W = VEC_W - CLASS_LSB;
   localparam int N_ARR = 2;   // searched arrays: 0 = pending, 1 = in service

   // ---------------------------------------------------------------
   // State
   // ---------------------------------------------------------------
   logic [NUM_VEC-1:0] irr_q, irr_d;
   logic [NUM_VEC-1:0] isr_q, isr_d;
   logic [NUM_VEC-1:0] tmr_q, tmr_d;
   logic [VEC_W-1:0]   tpr_q;

   logic [NUM_VEC-1:0] srch_bits  [N_ARR];
   logic               srch_found [N_ARR];
   logic [VEC_W-1:0]   srch_idx   [N_ARR];

   logic               irr_found, isr_found;
   logic [VEC_W-1:0]   irr_idx, isr_idx;
   logic               enabled, ack_fire, eoi_fire;

   assign srch_bits[0] = irr_q;
   assign srch_bits[1] = isr_q;

   for (genvar a = 0; a < N_ARR; a++) begin : g_srch
      vpr_find_highest #(
         .NUM_BITS (NUM_VEC),
         .WORD_W   (WORD_W),
         .STYLE    (STYLE)
      ) i_find (
         .bits_i  (srch_bits[a]),
         .found_o (srch_found[a]),
         .idx_o   (srch_idx[a])
      );
   end

   assign irr_found = srch_found[0];
   assign irr_idx   = srch_idx[0];
   assign isr_found = srch_found[1];
   assign isr_idx   = srch_idx[1];

   vpr_prio_calc #(
      .VEC_W     (VEC_W),
      .CLASS_LSB (CLASS_LSB)
   ) i_prio (
      .tpr_i       (tpr_q),
      .isr_found_i (isr_found),
      .isr_cls_i   (isr_idx[VEC_W-1:CLASS_LSB]),
      .ppr_o       (ppr)
   );

   vpr_deliver_gate #(
      .VEC_W     (VEC_W),
      .CLASS_LSB (CLASS_LSB)
   ) i_gate (
      .cand_found_i (irr_found),
      .cand_idx_i   (irr_idx),
      .ppr_i        (ppr),
      .dlv_valid_o  (dlv_valid),
      .dlv_vector_o (dlv_vector)
   );

   // ---------------------------------------------------------------
   // Strobe qualification
   // ---------------------------------------------------------------
   assign enabled  = hw_en && sw_en;
   assign acc_ok   = acc_valid && enabled && !irr_q[acc_vector];
   assign ack_fire = ack && dlv_valid;
   assign eoi_fire = eoi && isr_found;

   // Acknowledge and retirement act on the pre-edge state; the accept
   // is applied last so a new request's trigger kind wins over a clear.
   always_comb begin
      irr_d = irr_q;
      isr_d = isr_q;
      tmr_d = tmr_q;
      if (ack_fire) begin
         irr_d[dlv_vector] = 1'b0;
         isr_d[dlv_vector] = 1'b1;
      end
      if (eoi_fire) begin
         isr_d[isr_idx] = 1'b0;
         tmr_d[isr_idx] = 1'b0;
      end
      if (acc_ok) begin
         irr_d[acc_vector] = 1'b1;
         tmr_d[acc_vector] = acc_level;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irr_q      <= '0;
         isr_q      <= '0;
         tmr_q      <= '0;
         tpr_q      <= '0;
         eoi_done   <= 1'b0;
         eoi_vector <= '0;
         eoi_level  <= 1'b0;
      end else begin
         irr_q    <= irr_d;
         isr_q    <= isr_d;
         tmr_q    <= tmr_d;
         eoi_done <= eoi_fire;
         if (tpr_we) tpr_q <= tpr_wdata;
         if (eoi_fire) begin
            eoi_vector <= isr_idx;
            eoi_level  <= tmr_q[isr_idx];
         end
      end
   end

   // ---------------------------------------------------------------
   // Assertions
   // ---------------------------------------------------------------
   AST_ACC_SETS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      acc_ok |=> irr_q[$past(acc_vector)]);                            // R2

   AST_DISABLED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (!enabled && !ack_fire) |=> $stable(irr_q));                     // R3

   AST_OFFER_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
      dlv_valid |-> irr_q[dlv_vector]);                                // R4

   AST_OFFER_ABOVE_PPR: assert property (@(posedge clk) disable iff (!rst_n)
      dlv_valid |-> (dlv_vector[VEC_W-1:CLASS_LSB] > CLS_W'(ppr >> CLASS_LSB)) ||
                    ((dlv_vector[VEC_W-1:CLASS_LSB] == CLS_W'(ppr >> CLASS_LSB)) &&
                     (ppr[CLASS_LSB-1:0] == '0) && 1'b0));             // R6

   AST_ACK_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
      ack_fire |=> isr_q[$past(dlv_vector)] && !irr_q[$past(dlv_vector)]); // R7

   AST_EOI_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (eoi && (isr_q == '0)) |=> !eoi_done);                           // R8

   AST_EOI_RETIRED: assert property (@(posedge clk) disable iff (!rst_n)
      eoi_done |-> !isr_q[eoi_vector]);                                // R8

endmodule

// File: tb/test_vec_prio_resolver.sv
`timescale 1ns/1ps
module test_vec_prio_resolver;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       hw_en = 1'b1, sw_en = 1'b1;
   logic       acc_valid = 1'b0, acc_level = 1'b0;
   logic [7:0] acc_vector = 8'h00;
   logic       acc_ok;
   logic       ack = 1'b0, eoi = 1'b0, tpr_we = 1'b0;
   logic [7:0] tpr_wdata = 8'h00;
   logic       dlv_valid;
   logic [7:0] dlv_vector, ppr, eoi_vector;
   logic       eoi_done, eoi_level;

   int checks = 0;
   int errors = 0;
   logic [8:0] exp_q[$];   // {level, vector} expected on retirement
   logic       last_ok;

   always #2.5 clk = ~clk;   // 200 MHz

   vec_prio_resolver i_vec_prio_resolver (
      .clk, .rst_n, .hw_en, .sw_en, .acc_valid, .acc_vector, .acc_level,
      .acc_ok, .ack, .eoi, .tpr_we, .tpr_wdata, .dlv_valid, .dlv_vector,
      .ppr, .eoi_done, .eoi_vector, .eoi_level
   );

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // Monitor: pops the scoreboard on each retirement notification (R8, R9)
   always @(negedge clk) begin
      if (rst_n && eoi_done) begin
         if (exp_q.size() == 0) begin
            checks++; errors++;
            $display("FAIL R8 unexpected retirement actual=%0h expected=none", eoi_vector);
         end else begin
            logic [8:0] e;
            e = exp_q.pop_front();
            chk("R8 retired vector", eoi_vector, e[7:0]);
            chk("R9 retired trigger kind", eoi_level, e[8]);
         end
      end
   end

   // Inputs set at the falling edge, released 1 ns after the rising edge.
   task automatic do_accept(input logic [7:0] v, input logic lvl);
      @(negedge clk);
      acc_valid = 1'b1; acc_vector = v; acc_level = lvl;
      #1 last_ok = acc_ok;
      @(posedge clk); #1 acc_valid = 1'b0;
   endtask

   task automatic do_ack();
      @(negedge clk); ack = 1'b1;
      @(posedge clk); #1 ack = 1'b0;
   endtask

   task automatic do_eoi(input logic [7:0] v, input logic lvl, input bit expect_it);
      @(negedge clk); eoi = 1'b1;
      if (expect_it) exp_q.push_back({lvl, v});
      @(posedge clk); #1 eoi = 1'b0;
   endtask

   task automatic do_tpr(input logic [7:0] v);
      @(negedge clk); tpr_we = 1'b1; tpr_wdata = v;
      @(posedge clk); #1 tpr_we = 1'b0;
   endtask

   task automatic summary();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=finished");
      summary();
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      // R1: reset state
      chk("R1 dlv_valid", dlv_valid, 0);
      chk("R1 ppr", ppr, 8'h00);
      chk("R1 eoi_done", eoi_done, 0);
      chk("R1 acc_ok", acc_ok, 0);
      @(negedge clk) rst_n = 1'b1;
      @(posedge clk); #1;

      // R3: refused while either enable is low
      sw_en = 1'b0;
      do_accept(8'h50, 1'b0);
      chk("R3 sw_en low refuses", last_ok, 0);
      sw_en = 1'b1; hw_en = 1'b0;
      do_accept(8'h51, 1'b0);
      chk("R3 hw_en low refuses", last_ok, 0);
      hw_en = 1'b1;
      chk("R3 nothing pending after refusals", dlv_valid, 0);

      // R2: accept and duplicate
      do_accept(8'h21, 1'b0);
      chk("R2 accept new", last_ok, 1);
      chk("R4 single pending offered", dlv_vector, 8'h21);
      chk("R6 class 2 above ppr 0", dlv_valid, 1);
      do_accept(8'h21, 1'b1);
      chk("R2 duplicate refused", last_ok, 0);

      // R4: higher word outranks
      do_accept(8'hA3, 1'b1);
      do_accept(8'h47, 1'b0);
      do_accept(8'h45, 1'b0);
      chk("R4 highest across words", dlv_vector, 8'hA3);

      // R11, R6: task priority gating
      do_tpr(8'hB0);
      chk("R11 ppr follows tpr", ppr, 8'hB0);
      chk("R6 class below tpr blocked", dlv_valid, 0);
      do_tpr(8'hA0);
      chk("R6 equal class blocked", dlv_valid, 0);
      do_tpr(8'h9F);
      chk("R6 class above 9F offered", dlv_valid, 1);
      do_tpr(8'h00);

      // R7, R5: acknowledge
      do_ack();
      chk("R5 ppr from in-service class", ppr, 8'hA0);
      chk("R6 class 4 under ppr A0", dlv_valid, 0);
      do_ack();
      chk("R7 ignored ack keeps ppr", ppr, 8'hA0);
      do_tpr(8'hC0);
      chk("R5 tpr class wins", ppr, 8'hC0);
      do_tpr(8'h00);
      chk("R5 back to service class", ppr, 8'hA0);

      // R8, R9: retire level vector
      do_eoi(8'hA3, 1'b1, 1'b1);
      @(negedge clk); #1;
      chk("R5 ppr after retirement", ppr, 8'h00);
      chk("R7 unacked vector still pending", dlv_vector, 8'h47);

      // R10: acknowledge and end-of-interrupt in one cycle
      do_ack();
      do_accept(8'h90, 1'b0);
      chk("R4 new higher vector offered", dlv_vector, 8'h90);
      chk("R6 class 9 above ppr 40", dlv_valid, 1);
      @(negedge clk);
      ack = 1'b1; eoi = 1'b1;
      exp_q.push_back({1'b0, 8'h47});
      @(posedge clk); #1 ack = 1'b0; eoi = 1'b0;
      chk("R10 ppr from newly served vector", ppr, 8'h90);
      chk("R10 nothing above ppr 90", dlv_valid, 0);
      do_eoi(8'h90, 1'b0, 1'b1);
      chk("R8 pending 45 offered after retire", dlv_vector, 8'h45);

      // R10: accept and acknowledge in one cycle
      @(negedge clk);
      ack = 1'b1; acc_valid = 1'b1; acc_vector = 8'hE0; acc_level = 1'b0;
      #1 last_ok = acc_ok;
      chk("R10 offer before edge unchanged", dlv_vector, 8'h45);
      @(posedge clk); #1 ack = 1'b0; acc_valid = 1'b0;
      chk("R10 accept beside ack", last_ok, 1);
      chk("R10 ack took prior offer", ppr, 8'h40);
      chk("R10 new request offered after", dlv_vector, 8'hE0);
      do_ack();
      do_eoi(8'hE0, 1'b0, 1'b1);
      do_eoi(8'h45, 1'b0, 1'b1);
      chk("R4 lowest remaining offered", dlv_vector, 8'h21);

      // R9: level record replaced by a later edge request
      do_accept(8'h66, 1'b1);
      do_ack();
      do_eoi(8'h66, 1'b1, 1'b1);
      do_accept(8'h66, 1'b0);
      do_ack();
      do_eoi(8'h66, 1'b0, 1'b1);
      do_ack();
      do_eoi(8'h21, 1'b0, 1'b1);

      // R8: end of interrupt with nothing in service
      do_eoi(8'h00, 1'b0, 1'b0);
      @(negedge clk); #1;
      chk("R8 no notification when idle", eoi_done, 0);

      // R4 bit order inside a word, top vector, R6 low vectors
      do_accept(8'h20, 1'b0);
      do_accept(8'h3F, 1'b0);
      chk("R4 highest bit in word", dlv_vector, 8'h3F);
      do_accept(8'hFF, 1'b1);
      chk("R4 top vector", dlv_vector, 8'hFF);
      do_accept(8'h05, 1'b0);
      chk("R2 low vector accepted", last_ok, 1);
      do_ack();
      do_eoi(8'hFF, 1'b1, 1'b1);
      do_ack();
      do_eoi(8'h3F, 1'b0, 1'b1);
      do_ack();
      do_eoi(8'h20, 1'b0, 1'b1);
      chk("R6 vector below 0x10 never offered", dlv_valid, 0);

      repeat (3) @(negedge clk);
      chk("R8 all retirements seen", exp_q.size(), 0);
      summary();
      $finish;
   end

endmodule